// File: doc/BRIEF.md
# Load-Store Address Queue

This block keeps the decoded memory operations of an out-of-order core in program order, from decode until retirement. It is a circular buffer of `DEPTH` slots. Decode writes up to `LANES` new operations per cycle into consecutive slots at the tail. The queue hands each operation once to the address-calculation unit, strictly in program order. When an access cannot finish, because of a miss, an unresolved address conflict or a busy resource, the queue sends it again on a separate cache port until a completion arrives. A slot is not released when its operation issues. It stays allocated until the operation graduates, and it is released only from the head.

The cache, the translation unit and the address-conflict comparison lie outside the block. Their outcome reaches the block as a response naming a slot and telling whether the access finished or must be retried. Graduation is requested by naming one of the `LANES` oldest slots. A store that graduates drives the cache write strobe in that same cycle.

Top module: `ldst_addr_queue`

## Requirements
- R1: After reset the queue is empty: `free_slots` equals `DEPTH`, and `agu_valid`, `cache_valid`, `st_wr_valid` and `enq_stall` are low.
- R2: With `enq_cnt` = n accepted, lane k (k < n) is written into slot `enq_slot`+k modulo `DEPTH`, and `free_slots` falls by n after the clock edge.
- R3: When `enq_cnt` exceeds `LANES` or exceeds `free_slots`, `enq_stall` is high in that same cycle and no lane is written.
- R4: Each written slot is offered on the address-calculation port exactly once. Slots are offered in program order, at one per cycle, starting the cycle after they were written.
- R5: A response with `resp_done`=0 marks an issued slot for retry. The cache port offers the marked slot that is oldest relative to the head. The mark clears when `cache_ready` accepts the offer, so the slot is not offered again until another retry response arrives.
- R6: A response with `resp_done`=1 marks an issued slot complete. Responses for slots that are empty, not yet issued or already complete have no effect.
- R7: A graduation request with `grad_off`=j targets slot head+j. It is accepted only if that slot is complete and not yet graduated, and every older slot back to the head is complete. Otherwise it has no effect.
- R8: An accepted graduation of a store raises `st_wr_valid` in the same cycle, with the slot number and its tag. A load that graduates leaves `st_wr_valid` low.
- R9: Slots are released only from the head, up to `LANES` per cycle. Each released slot belongs to an unbroken run of graduated slots starting at the head. A slot is released on the clock edge after the one that recorded its graduation.
- R10: Slot numbers wrap from `DEPTH`-1 to 0. A completely full queue accepts nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_cnt | input | 3 | Number of lanes offered by decode this cycle |
| enq_is_store | input | 4 | Per lane: 1 for a store, 0 for a load |
| enq_tag | input | 32 | Per-lane tag, lane k in bits [8k+7:8k] |
| enq_stall | output | 1 | The offered lanes are refused this cycle |
| enq_slot | output | 4 | Slot that lane 0 would occupy |
| free_slots | output | 5 | Unallocated slots |
| agu_valid | output | 1 | A slot is issued to address calculation this cycle |
| agu_idx | output | 4 | Slot issued to address calculation |
| agu_tag | output | 8 | Tag of that slot |
| cache_ready | input | 1 | The cache port accepts a re-issue this cycle |
| cache_valid | output | 1 | A retry slot is offered to the cache |
| cache_idx | output | 4 | Slot offered to the cache |
| cache_tag | output | 8 | Tag of that slot |
| resp_valid | input | 1 | Access outcome is present |
| resp_idx | input | 4 | Slot the outcome refers to |
| resp_done | input | 1 | 1 = finished, 0 = must retry |
| grad_valid | input | 1 | Graduation request |
| grad_off | input | 2 | Offset of the graduating slot from the head |
| st_wr_valid | output | 1 | A store graduates and may write the cache |
| st_wr_idx | output | 4 | Slot of that store |
| st_wr_tag | output | 8 | Tag of that store |

## Verification
The bound checker watches several properties on every cycle. It checks that a refused cycle never shrinks the free count, that no slot is offered to address calculation twice in a row, and that the cache port offers only issued, incomplete slots. It also checks that the write strobe names only store slots and that the free count never climbs by more than `LANES` per cycle. The bench scenarios are needed for the rest. These are program-order issue, oldest-first retry selection before and after the wrap, refusal of graduation while an older slot is incomplete, release delayed until the head run is graduated, and the full-queue stall.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;

    localparam int LSQ_DEPTH = 16;
    localparam int LSQ_LANES = 4;
    localparam int LSQ_TAG_W = 8;

    // Per-slot state bits carried through the queue
    typedef struct packed {
        logic vld;
        logic is_st;
        logic issued;
        logic done;
        logic retry;
        logic grad;
    } lsq_flags_t;

    typedef enum logic {
        RESP_RETRY = 1'b0,
        RESP_DONE  = 1'b1
    } lsq_resp_e;

    // A slot may graduate once it is complete and has not graduated yet
    function automatic logic lsq_can_retire(lsq_flags_t f);
        return f.vld && f.done && !f.grad;
    endfunction

endpackage

// File: rtl/lsq_enq_ctrl.sv
`timescale 1ns/1ps
module lsq_enq_ctrl #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic [NW-1:0] enq_cnt,
    input  logic [CW-1:0] used,
    output logic          accept,
    output logic [CW-1:0] free
);
    always_comb begin
        free   = CW'(DEPTH) - used;
        accept = (int'(enq_cnt) <= LANES) && (int'(enq_cnt) <= int'(free));
    end
endmodule

// File: rtl/lsq_age_pick.sv
`timescale 1ns/1ps
module lsq_age_pick #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IW-1:0]    head,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // Scan from the head so the oldest requester wins after a wrap
    always_comb begin
        found = 1'b0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found && req[head + IW'(k)]) begin
                found = 1'b1;
                idx   = head + IW'(k);
            end
        end
    end
endmodule

// File: rtl/lsq_grad_ctrl.sv
`timescale 1ns/1ps
module lsq_grad_ctrl
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int NW = $clog2(LANES + 1),
    localparam int OW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  lsq_flags_t       flags [DEPTH],
    input  logic [IW-1:0]    head,
    input  logic             grad_valid,
    input  logic [OW-1:0]    grad_off,
    output logic             grad_ok,
    output logic [IW-1:0]    grad_idx,
    output logic [NW-1:0]    nfree
);
    logic older_ok;
    logic run;

    always_comb begin
        grad_idx = head + IW'(grad_off);
        older_ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(grad_off) && !flags[head + IW'(k)].done)
                older_ok = 1'b0;
        end
        grad_ok = grad_valid && older_ok && lsq_can_retire(flags[grad_idx]);

        // Release the unbroken run of graduated slots at the head
        nfree = '0;
        run   = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (run && flags[head + IW'(k)].grad)
                nfree = nfree + NW'(1);
            else
                run = 1'b0;
        end
    end
endmodule

// File: rtl/ldst_addr_queue.sv
`timescale 1ns/1ps
module ldst_addr_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH = LSQ_DEPTH,
    parameter int LANES = LSQ_LANES,
    parameter int TAG_W = LSQ_TAG_W,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1),
    localparam int OW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NW-1:0]          enq_cnt,
    input  logic [LANES-1:0]       enq_is_store,
    input  logic [LANES*TAG_W-1:0] enq_tag,
    output logic                   enq_stall,
    output logic [IW-1:0]          enq_slot,
    output logic [CW-1:0]          free_slots,
    output logic                   agu_valid,
    output logic [IW-1:0]          agu_idx,
    output logic [TAG_W-1:0]       agu_tag,
    input  logic                   cache_ready,
    output logic                   cache_valid,
    output logic [IW-1:0]          cache_idx,
    output logic [TAG_W-1:0]       cache_tag,
    input  logic                   resp_valid,
    input  logic [IW-1:0]          resp_idx,
    input  logic                   resp_done,
    input  logic                   grad_valid,
    input  logic [OW-1:0]          grad_off,
    output logic                   st_wr_valid,
    output logic [IW-1:0]          st_wr_idx,
    output logic [TAG_W-1:0]       st_wr_tag
);
    lsq_flags_t       flags_q [DEPTH];
    logic [TAG_W-1:0] tag_q   [DEPTH];
    logic [IW-1:0]    head_q, tail_q, iss_q;
    logic [CW-1:0]    used_q, free_w;
    logic             accept;
    logic             grad_ok;
    logic [IW-1:0]    grad_idx;
    logic [NW-1:0]    nfree;
    logic [DEPTH-1:0] retry_req, issued_v, done_v, st_v;
    logic [IW-1:0]    enq_pos [LANES];
    logic [IW-1:0]    rel_pos [LANES];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            assign retry_req[g] = flags_q[g].vld && flags_q[g].issued &&
                                  !flags_q[g].done && flags_q[g].retry;
            assign issued_v[g]  = flags_q[g].issued;
            assign done_v[g]    = flags_q[g].done;
            assign st_v[g]      = flags_q[g].is_st;
        end
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign enq_pos[l] = tail_q + IW'(l);
            assign rel_pos[l] = head_q + IW'(l);
        end
    endgenerate

    lsq_enq_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_enq (
        .enq_cnt (enq_cnt),
        .used    (used_q),
        .accept  (accept),
        .free    (free_w)
    );

    lsq_age_pick #(.DEPTH(DEPTH)) u_retry_pick (
        .req   (retry_req),
        .head  (head_q),
        .found (cache_valid),
        .idx   (cache_idx)
    );

    lsq_grad_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_grad (
        .flags      (flags_q),
        .head       (head_q),
        .grad_valid (grad_valid),
        .grad_off   (grad_off),
        .grad_ok    (grad_ok),
        .grad_idx   (grad_idx),
        .nfree      (nfree)
    );

    assign enq_stall   = !accept;
    assign enq_slot    = tail_q;
    assign free_slots  = free_w;
    assign agu_valid   = flags_q[iss_q].vld && !flags_q[iss_q].issued;
    assign agu_idx     = iss_q;
    assign agu_tag     = tag_q[iss_q];
    assign cache_tag   = tag_q[cache_idx];
    assign st_wr_valid = grad_ok && flags_q[grad_idx].is_st;
    assign st_wr_idx   = grad_idx;
    assign st_wr_tag   = tag_q[grad_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            iss_q  <= '0;
            used_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                flags_q[i] <= '0;
                tag_q[i]   <= '0;
            end
        end else begin
            if (accept) begin
                for (int l = 0; l < LANES; l++) begin
                    if (l < int'(enq_cnt)) begin
                        flags_q[enq_pos[l]] <= '{vld: 1'b1, is_st: enq_is_store[l], default: 1'b0};
                        tag_q[enq_pos[l]]   <= enq_tag[l*TAG_W +: TAG_W];
                    end
                end
                tail_q <= tail_q + IW'(enq_cnt);
            end
            if (agu_valid) begin
                flags_q[iss_q].issued <= 1'b1;
                iss_q <= iss_q + IW'(1);
            end
            if (cache_valid && cache_ready)
                flags_q[cache_idx].retry <= 1'b0;
            if (resp_valid && flags_q[resp_idx].vld && flags_q[resp_idx].issued &&
                !flags_q[resp_idx].done) begin
                if (resp_done == RESP_DONE) begin
                    flags_q[resp_idx].done  <= 1'b1;
                    flags_q[resp_idx].retry <= 1'b0;
                end else begin
                    flags_q[resp_idx].retry <= 1'b1;
                end
            end
            if (grad_ok)
                flags_q[grad_idx].grad <= 1'b1;
            for (int l = 0; l < LANES; l++) begin
                if (l < int'(nfree))
                    flags_q[rel_pos[l]] <= '0;
            end
            head_q <= head_q + IW'(nfree);
            used_q <= used_q + (accept ? CW'(enq_cnt) : '0) - CW'(nfree);
        end
    end
endmodule

// File: rtl/lsq_checker.sv
`timescale 1ns/1ps
module lsq_checker #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             enq_stall,
    input logic [CW-1:0]    free_slots,
    input logic             agu_valid,
    input logic [IW-1:0]    agu_idx,
    input logic             cache_valid,
    input logic [IW-1:0]    cache_idx,
    input logic [DEPTH-1:0] issued_v,
    input logic [DEPTH-1:0] done_v,
    input logic [DEPTH-1:0] st_v,
    input logic             st_wr_valid,
    input logic [IW-1:0]    st_wr_idx
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        int'(free_slots) <= DEPTH);

    p_refused_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        enq_stall |=> int'(free_slots) >= int'($past(free_slots)));

    p_issue_once_r4: assert property (@(posedge clk) disable iff (rst)
        agu_valid |=> !(agu_valid && agu_idx == $past(agu_idx)));

    p_retry_target_r5: assert property (@(posedge clk) disable iff (rst)
        cache_valid |-> (issued_v[cache_idx] && !done_v[cache_idx]));

    p_store_write_r8: assert property (@(posedge clk) disable iff (rst)
        st_wr_valid |-> st_v[st_wr_idx]);

    p_release_rate_r9: assert property (@(posedge clk) disable iff (rst)
        int'(free_slots) <= int'($past(free_slots)) + LANES);
endmodule

bind ldst_addr_queue lsq_checker #(.DEPTH(DEPTH), .LANES(LANES)) u_lsq_chk (
    .clk         (clk),
    .rst         (rst),
    .enq_stall   (enq_stall),
    .free_slots  (free_slots),
    .agu_valid   (agu_valid),
    .agu_idx     (agu_idx),
    .cache_valid (cache_valid),
    .cache_idx   (cache_idx),
    .issued_v    (issued_v),
    .done_v      (done_v),
    .st_v        (st_v),
    .st_wr_valid (st_wr_valid),
    .st_wr_idx   (st_wr_idx)
);

// File: tb/ldst_addr_queue_test.sv
`timescale 1ns/1ps
module ldst_addr_queue_test;
    localparam int DEPTH = 16;
    localparam int LANES = 4;
    localparam int TW    = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       enq_cnt = '0;
    logic [3:0]       enq_is_store = '0;
    logic [31:0]      enq_tag = '0;
    logic             enq_stall;
    logic [3:0]       enq_slot;
    logic [4:0]       free_slots;
    logic             agu_valid;
    logic [3:0]       agu_idx;
    logic [7:0]       agu_tag;
    logic             cache_ready = 1'b1;
    logic             cache_valid;
    logic [3:0]       cache_idx;
    logic [7:0]       cache_tag;
    logic             resp_valid = 1'b0;
    logic [3:0]       resp_idx = '0;
    logic             resp_done = 1'b0;
    logic             grad_valid = 1'b0;
    logic [1:0]       grad_off = '0;
    logic             st_wr_valid;
    logic [3:0]       st_wr_idx;
    logic [7:0]       st_wr_tag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ldst_addr_queue uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic respond(input int idx, input bit fin);
        resp_valid = 1'b1; resp_idx = 4'(idx); resp_done = fin;
        step();
        resp_valid = 1'b0;
    endtask

    task automatic graduate(input int off);
        grad_valid = 1'b1; grad_off = 2'(off);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 free", free_slots, DEPTH);
        chk("R1 agu_valid", agu_valid, 0);
        chk("R1 cache_valid", cache_valid, 0);
        chk("R1 st_wr_valid", st_wr_valid, 0);
        chk("R1 stall", enq_stall, 0);

        // R2: four lanes, lanes 1 and 3 are stores, tags 10..13
        enq_cnt = 3'd4; enq_is_store = 4'b1010;
        for (int k = 0; k < LANES; k++) enq_tag[k*TW +: TW] = 8'(10 + k);
        #1;
        chk("R2 stall", enq_stall, 0);
        chk("R2 slot", enq_slot, 0);
        step();
        enq_cnt = '0;
        #1;
        chk("R2 free", free_slots, DEPTH - 4);

        // R4: program-order issue, one per cycle
        for (int k = 0; k < 4; k++) begin
            chk("R4 agu_valid", agu_valid, 1);
            chk("R4 agu_idx", agu_idx, k);
            chk("R4 agu_tag", agu_tag, 10 + k);
            step();
        end
        #1;
        chk("R4 no reissue", agu_valid, 0);

        // R3: more lanes than exist
        enq_cnt = 3'd5;
        #1;
        chk("R3 stall over lanes", enq_stall, 1);
        step();
        enq_cnt = '0;
        #1;
        chk("R3 nothing written", free_slots, DEPTH - 4);

        // R5: retries held back, oldest picked first
        cache_ready = 1'b0;
        respond(1, 1'b0);
        respond(0, 1'b0);
        #1;
        chk("R5 valid", cache_valid, 1);
        chk("R5 oldest", cache_idx, 0);
        chk("R5 tag", cache_tag, 10);
        cache_ready = 1'b1;
        step();
        #1;
        chk("R5 next", cache_idx, 1);
        step();
        #1;
        chk("R5 no repeat", cache_valid, 0);

        // R6: completions for slots 0, 1, 3
        respond(0, 1'b1);
        respond(1, 1'b1);
        respond(3, 1'b1);
        #1;
        chk("R6 done clears retry", cache_valid, 0);

        // R7: slot 3 blocked by incomplete slot 2
        graduate(3);
        #1;
        chk("R7 refused", st_wr_valid, 0);
        step();
        grad_valid = 1'b0;

        // R8: store in slot 1 graduates ahead of head
        graduate(1);
        #1;
        chk("R8 store write", st_wr_valid, 1);
        chk("R8 store idx", st_wr_idx, 1);
        chk("R8 store tag", st_wr_tag, 11);
        step();
        graduate(0);
        #1;
        chk("R8 load no write", st_wr_valid, 0);
        step();
        grad_valid = 1'b0;
        #1;
        chk("R9 not yet released", free_slots, DEPTH - 4);
        step();
        #1;
        chk("R9 released run", free_slots, DEPTH - 2);

        // R6/R7: complete slot 2, graduate it; slot 3 must stay allocated
        respond(2, 1'b1);
        graduate(0);
        step();
        grad_valid = 1'b0;
        step();
        #1;
        chk("R7 refused left no mark", free_slots, DEPTH - 1);
        graduate(0);
        #1;
        chk("R8 store idx 3", st_wr_idx, 3);
        chk("R8 store tag 13", st_wr_tag, 13);
        step();
        grad_valid = 1'b0;
        step();
        #1;
        chk("R9 empty again", free_slots, DEPTH);

        // R10: fill all slots from slot 4, wrapping past the top
        for (int c = 0; c < 4; c++) begin
            enq_cnt = 3'd4; enq_is_store = 4'b0000;
            for (int k = 0; k < LANES; k++)
                enq_tag[k*TW +: TW] = 8'(100 + (4 + 4*c + k) % DEPTH);
            #1;
            chk("R10 slot", enq_slot, (4 + 4*c) % DEPTH);
            if (c > 0) chk("R4 agu_idx during fill", agu_idx, 4 + c - 1);
            step();
        end
        enq_cnt = 3'd1;
        #1;
        chk("R3 full stall", enq_stall, 1);
        chk("R10 full", free_slots, 0);
        enq_cnt = '0;
        for (int n = 3; n < DEPTH; n++) begin
            #1;
            chk("R10 agu_idx wrap", agu_idx, (4 + n) % DEPTH);
            chk("R10 agu_tag wrap", agu_tag, 100 + (4 + n) % DEPTH);
            step();
        end
        #1;
        chk("R4 all issued", agu_valid, 0);

        // R5: head-relative priority after wrap (head is 4)
        cache_ready = 1'b0;
        respond(0, 1'b0);
        respond(15, 1'b0);
        #1;
        chk("R5 wrap oldest", cache_idx, 15);
        cache_ready = 1'b1;
        step();
        #1;
        chk("R5 wrap next", cache_idx, 0);
        step();
        #1;
        chk("R5 wrap drained", cache_valid, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule